// File: doc/BRIEF.md
# Privileged Command Enqueue Unit

This block carries out one privileged 64-byte command enqueue. A requester presents a 512-bit command, a destination address, the current privilege level, a feature-enable bit and a lock-prefix indication. The unit captures the request and checks it for faults. If the request is clean, the unit sends the whole command toward a device enqueue register as a single non-cached 512-bit store. It then waits for the one-bit completion status from the device and turns that status into the zero flag.

A faulting request never reaches the store port. The fault is reported as a code when the operation finishes. A destination outside the enqueue-register window is also never stored: the unit drops the write and reports the retry status. The unit processes one command at a time. It only accepts a new request once the previous one has finished with its one-cycle `done` pulse.

Top module: `cmd_enq_issue`

## Requirements
- R1: `req_ready` is high only when the unit is idle. A request presented while a command is in flight is ignored: it has no effect on the stored data, the stored address or the outcome.
- R2: If `req_lock` is 1 or `req_feat_en` is 0, the outcome is exception code 1 (undefined opcode). This fault takes priority over every other fault.
- R3: If the privilege level is not 0, and R2 does not apply, the outcome is exception code 2.
- R4: If address bits 5:0 are not all zero, and neither R2 nor R3 applies, the outcome is exception code 3. Every issued store carries an address whose bits 5:0 are zero.
- R5: If any bit 30 down to 20 of the command is set, and no higher-priority fault applies, the outcome is exception code 4. Command bit 0 is `req_cmd[0]`.
- R6: A faulting request issues no store. It finishes with `zf` = 0 and all other flags 0.
- R7: A clean request to the enqueue window issues exactly one store. The store carries the 512 captured command bits and the captured address. `st_valid`, `st_data` and `st_addr` stay unchanged until `st_ready` is seen.
- R8: After the store, the unit waits for `rsp_valid`. It then finishes with `zf` equal to `rsp_retry` (1 = retry, 0 = success), `oth_flags` = 0 and exception code 0.
- R9: A clean request whose address lies outside the enqueue window (the address bits above bit 11 differ from the window base) issues no store. It finishes with `zf` = 1 and exception code 0.
- R10: `done` is high for exactly one cycle per accepted request. `exc_code`, `zf` and `oth_flags` are valid in that cycle.
- R11: After reset: `req_ready` = 1, `st_valid` = 0, `done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request will be taken |
| req_cmd | input | 512 | 64-byte command |
| req_addr | input | ADDR_W | Destination address |
| req_cpl | input | CPL_W | Current privilege level |
| req_feat_en | input | 1 | Feature enabled |
| req_lock | input | 1 | Lock prefix present |
| st_valid | output | 1 | Store offered to device |
| st_ready | input | 1 | Device takes store |
| st_addr | output | ADDR_W | Store address |
| st_data | output | 512 | Store payload |
| rsp_valid | input | 1 | Completion status present |
| rsp_retry | input | 1 | 1 = retry, 0 = success |
| done | output | 1 | Operation finished |
| exc_code | output | 3 | 0 none, 1 undefined opcode, 2 privilege, 3 alignment, 4 reserved bits |
| zf | output | 1 | Zero flag result |
| oth_flags | output | 5 | Remaining arithmetic flags, always cleared |

## Verification
The bench exercises every combination of lock, feature enable, privilege level, alignment, reserved bits, window hit and completion status. Device stalls of varying length are mixed in. Errors in the captured registers show up directly at the store port: a wrong payload or address appears on `st_data` or `st_addr` in the same cycle the store is offered. Errors in the fault priority or the status path show up at the next `done` pulse, two cycles after acceptance for faults and one cycle after the status for issued stores. An error in the state machine shows up as a missing or repeated store, or as `req_ready` rising while a command is still in flight.

// File: rtl/cmd_enq_pkg.sv
package cmd_enq_pkg;

    typedef enum logic [2:0] {
        EXC_NONE     = 3'd0,
        EXC_UD       = 3'd1,
        EXC_GP_PRIV  = 3'd2,
        EXC_GP_ALIGN = 3'd3,
        EXC_GP_RSVD  = 3'd4
    } exc_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_ISSUE = 3'd2,
        ST_WAIT  = 3'd3,
        ST_DONE  = 3'd4
    } state_e;

endpackage

// File: rtl/cmd_enq_fault.sv
module cmd_enq_fault
    import cmd_enq_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter int              CPL_W      = 2,
    parameter int              ALIGN_BITS = 6,
    parameter int              WIN_LOG2   = 12,
    parameter int              RSVD_W     = 11,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0010_0000
) (
    input  logic                       lock,
    input  logic                       feat_en,
    input  logic [CPL_W-1:0]           cpl,
    input  logic [ALIGN_BITS-1:0]      addr_lo,
    input  logic [ADDR_W-WIN_LOG2-1:0] addr_hi,
    input  logic [RSVD_W-1:0]          rsvd,
    output exc_e                       exc,
    output logic                       win_hit
);

    // Priority: undefined opcode, privilege, alignment, reserved bits
    always_comb begin
        if (lock || !feat_en)         exc = EXC_UD;
        else if (cpl != '0)           exc = EXC_GP_PRIV;
        else if (addr_lo != '0)       exc = EXC_GP_ALIGN;
        else if (rsvd != '0)          exc = EXC_GP_RSVD;
        else                          exc = EXC_NONE;
    end

    assign win_hit = (addr_hi == WIN_BASE[ADDR_W-1:WIN_LOG2]);

endmodule

// File: rtl/cmd_enq_ctrl.sv
module cmd_enq_ctrl
    import cmd_enq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 512,
    parameter int CPL_W      = 2,
    parameter int ALIGN_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DATA_W-1:0] req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CPL_W-1:0]  req_cpl,
    input  logic              req_feat_en,
    input  logic              req_lock,
    output logic [DATA_W-1:0] cap_cmd,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [CPL_W-1:0]  cap_cpl,
    output logic              cap_feat_en,
    output logic              cap_lock,
    input  exc_e              chk_exc,
    input  logic              chk_hit,
    output logic              st_valid,
    input  logic              st_ready,
    output logic [ADDR_W-1:0] st_addr,
    output logic [DATA_W-1:0] st_data,
    input  logic              rsp_valid,
    input  logic              rsp_retry,
    output logic              done,
    output exc_e              exc_code,
    output logic              zf
);

    typedef struct packed {
        state_e              state;
        logic [DATA_W-1:0]   cmd;
        logic [ADDR_W-1:0]   addr;
        logic [CPL_W-1:0]    cpl;
        logic                feat_en;
        logic                lock;
        exc_e                exc;
        logic                zf;
    } ctrl_t;

    ctrl_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.state   = ST_CHECK;
                    r_d.cmd     = req_cmd;
                    r_d.addr    = req_addr;
                    r_d.cpl     = req_cpl;
                    r_d.feat_en = req_feat_en;
                    r_d.lock    = req_lock;
                    r_d.exc     = EXC_NONE;
                    r_d.zf      = 1'b0;
                end
            end
            ST_CHECK: begin
                if (chk_exc != EXC_NONE) begin
                    r_d.exc   = chk_exc;
                    r_d.zf    = 1'b0;
                    r_d.state = ST_DONE;
                end else if (!chk_hit) begin
                    r_d.zf    = 1'b1;
                    r_d.state = ST_DONE;
                end else begin
                    r_d.state = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (st_ready) r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    r_d.zf    = rsp_retry;
                    r_d.state = ST_DONE;
                end
            end
            ST_DONE:  r_d.state = ST_IDLE;
            default:  r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, cmd: '0, addr: '0, cpl: '0,
                     feat_en: 1'b0, lock: 1'b0, exc: EXC_NONE, zf: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready   = (r_q.state == ST_IDLE);
    assign st_valid    = (r_q.state == ST_ISSUE);
    assign done        = (r_q.state == ST_DONE);
    assign st_addr     = r_q.addr;
    assign st_data     = r_q.cmd;
    assign exc_code    = r_q.exc;
    assign zf          = r_q.zf;
    assign cap_cmd     = r_q.cmd;
    assign cap_addr    = r_q.addr;
    assign cap_cpl     = r_q.cpl;
    assign cap_feat_en = r_q.feat_en;
    assign cap_lock    = r_q.lock;

    p_no_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid || done) |-> !req_ready);

    p_store_priv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (r_q.cpl == '0 && !r_q.lock && r_q.feat_en));

    p_store_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (st_addr[ALIGN_BITS-1:0] == '0));

    p_fault_zf_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && exc_code != EXC_NONE) |-> !zf);

    p_store_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_data) && $stable(st_addr)));

    p_status_zf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT && rsp_valid) |=> (done && zf == $past(rsp_retry)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/cmd_enq_issue.sv
module cmd_enq_issue
    import cmd_enq_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                CMD_BYTES  = 64,
    parameter int                CPL_W      = 2,
    parameter int                RSVD_LO    = 20,
    parameter int                RSVD_HI    = 30,
    parameter int                WIN_LOG2   = 12,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h0010_0000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [CMD_BYTES*8-1:0] req_cmd,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [CPL_W-1:0]      req_cpl,
    input  logic                  req_feat_en,
    input  logic                  req_lock,
    output logic                  st_valid,
    input  logic                  st_ready,
    output logic [ADDR_W-1:0]     st_addr,
    output logic [CMD_BYTES*8-1:0] st_data,
    input  logic                  rsp_valid,
    input  logic                  rsp_retry,
    output logic                  done,
    output logic [2:0]            exc_code,
    output logic                  zf,
    output logic [4:0]            oth_flags
);

    localparam int DATA_W     = CMD_BYTES * 8;
    localparam int ALIGN_BITS = $clog2(CMD_BYTES);
    localparam int RSVD_W     = RSVD_HI - RSVD_LO + 1;

    logic [DATA_W-1:0] cap_cmd;
    logic [ADDR_W-1:0] cap_addr;
    logic [CPL_W-1:0]  cap_cpl;
    logic              cap_feat_en;
    logic              cap_lock;
    exc_e              chk_exc;
    logic              chk_hit;
    exc_e              exc_q;

    cmd_enq_fault #(
        .ADDR_W(ADDR_W), .CPL_W(CPL_W), .ALIGN_BITS(ALIGN_BITS),
        .WIN_LOG2(WIN_LOG2), .RSVD_W(RSVD_W), .WIN_BASE(WIN_BASE)
    ) u_fault (
        .lock    (cap_lock),
        .feat_en (cap_feat_en),
        .cpl     (cap_cpl),
        .addr_lo (cap_addr[ALIGN_BITS-1:0]),
        .addr_hi (cap_addr[ADDR_W-1:WIN_LOG2]),
        .rsvd    (cap_cmd[RSVD_HI:RSVD_LO]),
        .exc     (chk_exc),
        .win_hit (chk_hit)
    );

    cmd_enq_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CPL_W(CPL_W), .ALIGN_BITS(ALIGN_BITS)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_cmd     (req_cmd),
        .req_addr    (req_addr),
        .req_cpl     (req_cpl),
        .req_feat_en (req_feat_en),
        .req_lock    (req_lock),
        .cap_cmd     (cap_cmd),
        .cap_addr    (cap_addr),
        .cap_cpl     (cap_cpl),
        .cap_feat_en (cap_feat_en),
        .cap_lock    (cap_lock),
        .chk_exc     (chk_exc),
        .chk_hit     (chk_hit),
        .st_valid    (st_valid),
        .st_ready    (st_ready),
        .st_addr     (st_addr),
        .st_data     (st_data),
        .rsp_valid   (rsp_valid),
        .rsp_retry   (rsp_retry),
        .done        (done),
        .exc_code    (exc_q),
        .zf          (zf)
    );

    assign exc_code  = exc_q;
    assign oth_flags = '0;

    p_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (st_addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]));

    p_fault_priority_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cap_lock || !cap_feat_en)) |-> (exc_code == 3'd1));

endmodule

// File: tb/cmd_enq_issue_bench.sv
`timescale 1ns/1ps
module cmd_enq_issue_bench;

    localparam int ADDR_W = 32;
    localparam int DW     = 512;
    localparam logic [31:0] BASE = 32'h0010_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [DW-1:0] req_cmd = '0;
    logic [31:0]   req_addr = '0;
    logic [1:0]    req_cpl = '0;
    logic          req_feat_en = 1'b0;
    logic          req_lock = 1'b0;
    logic          st_valid;
    logic          st_ready = 1'b0;
    logic [31:0]   st_addr;
    logic [DW-1:0] st_data;
    logic          rsp_valid = 1'b0;
    logic          rsp_retry = 1'b0;
    logic          done;
    logic [2:0]    exc_code;
    logic          zf;
    logic [4:0]    oth_flags;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cmd_enq_issue u_cmd_enq_issue (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_cpl(req_cpl),
        .req_feat_en(req_feat_en), .req_lock(req_lock), .st_valid(st_valid),
        .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
        .rsp_valid(rsp_valid), .rsp_retry(rsp_retry), .done(done),
        .exc_code(exc_code), .zf(zf), .oth_flags(oth_flags)
    );

    task automatic chk(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mk_cmd(input int idx, input bit rsvd);
        logic [DW-1:0] c;
        for (int k = 0; k < DW/32; k++)
            c[k*32 +: 32] = (32'(idx) * 32'h9E37_79B9) ^ (32'(k) * 32'h0100_0193);
        c[30:20] = '0;
        if (rsvd) c[20 + (idx % 11)] = 1'b1;
        return c;
    endfunction

    task automatic run_one(input int idx);
        bit            lock   = idx[0];
        bit            feat   = idx[1];
        logic [1:0]    cpl    = idx[3:2];
        bit            mis    = idx[4];
        bit            rsvd   = idx[5];
        bit            outwin = idx[6];
        bit            retry  = idx[7];
        logic [DW-1:0] cmd    = mk_cmd(idx, rsvd);
        logic [31:0]   addr;
        logic [2:0]    exp_exc;
        bit            exp_store, exp_zf;
        int            stall  = idx % 3;
        int            rdly   = (idx % 2) + 1;
        int            stall_ctr = 0, rsp_ctr = 0, stores = 0, busy_ready = 0;
        bit            xfered = 0, got_done = 0, hold_bad = 0, seen_first = 0;
        logic [DW-1:0] got_data = '0, first_data = '0;
        logic [31:0]   got_addr = '0;
        logic [2:0]    got_exc = '0;
        bit            got_zf = 0;
        logic [4:0]    got_oth = '0;

        addr = (outwin ? 32'h0020_0000 : BASE) + 32'((idx % 64) * 64) + (mis ? 32'((idx % 63) + 1) : 32'd0);
        if (lock || !feat)   exp_exc = 3'd1;
        else if (cpl != 0)   exp_exc = 3'd2;
        else if (mis)        exp_exc = 3'd3;
        else if (rsvd)       exp_exc = 3'd4;
        else                 exp_exc = 3'd0;
        exp_store = (exp_exc == 0) && !outwin;
        exp_zf    = (exp_exc != 0) ? 1'b0 : (outwin ? 1'b1 : retry);

        @(negedge clk);
        req_valid = 1'b1; req_cmd = cmd; req_addr = addr; req_cpl = cpl;
        req_feat_en = feat; req_lock = lock;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (done) begin
                got_done = 1; got_exc = exc_code; got_zf = zf; got_oth = oth_flags;
                req_valid = 1'b0; st_ready = 1'b0; rsp_valid = 1'b0;
                break;
            end
            if (req_ready) busy_ready++;
            // junk request while busy: must be ignored
            req_valid = 1'b1; req_cmd = ~cmd; req_addr = addr ^ 32'h40;
            req_cpl = 2'd0; req_feat_en = 1'b1; req_lock = 1'b0;
            if (st_valid) begin
                if (!seen_first) begin first_data = st_data; seen_first = 1; end
                else if (st_data != first_data) hold_bad = 1;
                if (stall_ctr == stall) begin
                    st_ready = 1'b1; stores++; got_data = st_data; got_addr = st_addr; xfered = 1;
                end else begin
                    st_ready = 1'b0; stall_ctr++;
                end
            end else begin
                st_ready = 1'b0;
                if (xfered) begin
                    if (rsp_ctr == rdly) begin rsp_valid = 1'b1; rsp_retry = retry; end
                    else begin rsp_valid = 1'b0; rsp_ctr++; end
                end
            end
        end
        chk("R10 done seen", got_done, 64'(got_done), 64'd1);
        chk("R1 ready low while busy", busy_ready == 0, 64'(busy_ready), 64'd0);
        chk($sformatf("R2/R3/R4/R5 exc idx %0d", idx), got_exc == exp_exc, 64'(got_exc), 64'(exp_exc));
        chk($sformatf("R8/R9/R6 zf idx %0d", idx), got_zf == exp_zf, 64'(got_zf), 64'(exp_zf));
        chk("R8 other flags clear", got_oth == 0, 64'(got_oth), 64'd0);
        chk($sformatf("R6/R7/R9 store count idx %0d", idx), stores == (exp_store ? 1 : 0), 64'(stores), 64'(exp_store));
        if (exp_store) begin
            chk("R7 R1 store data", got_data == cmd, got_data[63:0], cmd[63:0]);
            chk("R7 R1 store data high", got_data[DW-1:DW-64] == cmd[DW-1:DW-64], got_data[DW-1:DW-64], cmd[DW-1:DW-64]);
            chk("R7 R1 store addr", got_addr == addr, 64'(got_addr), 64'(addr));
            chk("R7 store hold", !hold_bad, 64'(hold_bad), 64'd0);
            chk("R4 store aligned", got_addr[5:0] == 0, 64'(got_addr[5:0]), 64'd0);
        end
        @(negedge clk);
        chk("R10 done one cycle", done == 1'b0, 64'(done), 64'd0);
        chk("R1 ready after done", req_ready == 1'b1, 64'(req_ready), 64'd1);
        chk("R6 no late store", st_valid == 1'b0, 64'(st_valid), 64'd0);
    endtask

    initial begin
        #1;
        chk("R11 reset ready", req_ready == 1'b1, 64'(req_ready), 64'd1);
        chk("R11 reset st_valid", st_valid == 1'b0, 64'(st_valid), 64'd0);
        chk("R11 reset done", done == 1'b0, 64'(done), 64'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 ready after reset", req_ready == 1'b1, 64'(req_ready), 64'd1);
        chk("R11 idle after reset", (st_valid | done) == 1'b0, 64'(st_valid | done), 64'd0);
        for (int idx = 0; idx < 256; idx++) run_one(idx);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule